// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Flag Unit

This unit watches five external interrupt pins, one auxiliary trigger input and a group of eight wakeup pins. For every pin, software picks whether a rising or a falling transition counts as an event. Each recognised event sets a sticky request flag, which stays set until software clears it. A per-source enable bit gates each flag into a single combined interrupt request line. Deciding priority, vectoring and taking the exception all happen further downstream.

Software reaches the unit through a simple byte-wide bus with an address, a write strobe, write data and combinational read data. Each pin first passes through a two-stage synchronizer. An event is recognised when the newest synchronized sample differs from the one before it and equals the selected polarity. Software can clear a flag but can never set one.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset the registers read as follows: sense 0xE0, enable A 0x00, enable B 0x00, flag A 0x00, flag B 0x20, wakeup flags 0x00, wakeup sense 0x00. The irq output is 0.
- R2: Bits 7:5 of the sense register always read 1 and ignore writes. Bits 4:0 are written and read back as given.
- R3: Sense bit n (0 = falling, 1 = rising) sets the active transition of irq_pin[n]. Wakeup sense bit k does the same for wake_pin[k]. A transition of the other direction sets no flag.
- R4: An active transition on a pin, applied just after a clock edge, sets its flag at the third rising clock edge after that. The flag then stays set after the pin settles.
- R5: Writing a 0 to a flag bit clears it. Writing a 1 leaves it unchanged. No write can set a flag.
- R6: If a pin event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: Changing a sense bit while the pin holds a steady level sets no flag.
- R8: The aux_trig input uses sense bit 4 as its polarity, the same bit as irq_pin[4]. Its event sets flag B bit 0.
- R9: irq_o is 1 when any enabled flag is set. Enable A bits 4:0 gate flag A bits 4:0. Enable A bit 5 gates flag B bit 0. Enable A bit 6 gates flag B bit 5. Enable B bit k gates wakeup flag bit k.
- R10: The registers sit at these addresses: sense 0xFFF2, enable A 0xFFF3, enable B 0xFFF4, flag A 0xFFF6, flag B 0xFFF7, wakeup flags 0xFFF9, wakeup sense 0xFF90. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq_pin | input | 5 | External interrupt pins |
| aux_trig | input | 1 | Auxiliary trigger input, polarity shared with irq_pin[4] |
| wake_pin | input | 8 | Wakeup pins |
| irq_o | output | 1 | Combined enabled interrupt request |

## Verification
The bench lines up a pin event with a clearing write in the same cycle. A design in which the clear wins would lose that event. It flips sense bits while pins hold a steady level, which catches a detector that compares against the polarity instead of against the previous sample and so raises spurious flags. It writes all ones to the flag registers and to the reserved sense bits: a design that treats flags as plain storage, or lets the reserved bits be written, reads back different values. It also counts the exact cycle in which a flag appears, which exposes a missing or extra synchronizer stage.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SENSE      = 16'hFFF2;
    localparam logic [ADDR_W-1:0] A_MASK_A     = 16'hFFF3;
    localparam logic [ADDR_W-1:0] A_MASK_B     = 16'hFFF4;
    localparam logic [ADDR_W-1:0] A_FLAG_A     = 16'hFFF6;
    localparam logic [ADDR_W-1:0] A_FLAG_B     = 16'hFFF7;
    localparam logic [ADDR_W-1:0] A_WAKE_FLAG  = 16'hFFF9;
    localparam logic [ADDR_W-1:0] A_WAKE_SENSE = 16'hFF90;

    localparam logic [DATA_W-1:0] SENSE_RSVD = 8'hE0;
    localparam logic [DATA_W-1:0] FLAG_B_RST = 8'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SENSE,
        SEL_MASK_A,
        SEL_MASK_B,
        SEL_FLAG_A,
        SEL_FLAG_B,
        SEL_WAKE_FLAG,
        SEL_WAKE_SENSE
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] sense;
        logic [DATA_W-1:0] mask_a;
        logic [DATA_W-1:0] mask_b;
        logic [DATA_W-1:0] wsense;
    } ctrl_regs_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_SENSE:      return SEL_SENSE;
            A_MASK_A:     return SEL_MASK_A;
            A_MASK_B:     return SEL_MASK_B;
            A_FLAG_A:     return SEL_FLAG_A;
            A_FLAG_B:     return SEL_FLAG_B;
            A_WAKE_FLAG:  return SEL_WAKE_FLAG;
            A_WAKE_SENSE: return SEL_WAKE_SENSE;
            default:      return SEL_NONE;
        endcase
    endfunction

    // A polarity bit of 1 means rising, 0 means falling.
    function automatic logic is_event(input logic cur, input logic prev, input logic pol);
        return (cur != prev) && (cur == pol);
    endfunction

endpackage

// File: rtl/pin_edge_det.sv
module pin_edge_det #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] evt_o
);
    import edgeirq_pkg::*;

    logic [W-1:0] sync_q [STAGES];
    logic [W-1:0] prev_q;
    logic [W-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign cur = sync_q[STAGES-1];

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign evt_o[i] = is_event(cur[i], prev_q[i], pol_i[i]);
    end

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] keep;

    // A zero in the write data drops that bit; a one keeps it.
    assign keep = clr_we_i ? clr_data_i : '1;

    always_ff @(posedge clk) begin
        if (rst) flag_o <= RST_VAL;
        else     flag_o <= (flag_o & keep) | set_i;
    end

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit #(
    parameter int N_IRQ   = 5,
    parameter int N_WAKE  = 8,
    parameter int STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [4:0]  irq_pin,
    input  logic        aux_trig,
    input  logic [7:0]  wake_pin,
    output logic        irq_o
);
    import edgeirq_pkg::*;

    localparam int N_DET = N_IRQ + 1;

    ctrl_regs_t   ctrl_q;
    reg_sel_e     sel;
    logic [N_DET-1:0] det_evt;
    logic [N_WAKE-1:0] wake_evt;
    logic [7:0]   set_a, set_b, set_w;
    logic [7:0]   flag_a, flag_b, flag_w;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.sense  <= SENSE_RSVD;
            ctrl_q.mask_a <= '0;
            ctrl_q.mask_b <= '0;
            ctrl_q.wsense <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_SENSE:      ctrl_q.sense  <= bus_wdata | SENSE_RSVD;
                SEL_MASK_A:     ctrl_q.mask_a <= bus_wdata;
                SEL_MASK_B:     ctrl_q.mask_b <= bus_wdata;
                SEL_WAKE_SENSE: ctrl_q.wsense <= bus_wdata;
                default: ;
            endcase
        end
    end

    // The aux trigger sits above the pins and shares the top pin's polarity.
    pin_edge_det #(.W(N_DET), .STAGES(STAGES)) u_det_irq (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({aux_trig, irq_pin}),
        .pol_i ({ctrl_q.sense[N_IRQ-1], ctrl_q.sense[N_IRQ-1:0]}),
        .evt_o (det_evt)
    );

    pin_edge_det #(.W(N_WAKE), .STAGES(STAGES)) u_det_wake (
        .clk   (clk),
        .rst   (rst),
        .pin_i (wake_pin),
        .pol_i (ctrl_q.wsense[N_WAKE-1:0]),
        .evt_o (wake_evt)
    );

    assign set_a = 8'(det_evt[N_IRQ-1:0]);
    assign set_b = {7'b0, det_evt[N_IRQ]};
    assign set_w = 8'(wake_evt);

    sticky_flags #(.W(8), .RST_VAL(8'h00)) u_flag_a (
        .clk(clk), .rst(rst), .set_i(set_a),
        .clr_we_i(bus_we && sel == SEL_FLAG_A), .clr_data_i(bus_wdata),
        .flag_o(flag_a)
    );

    sticky_flags #(.W(8), .RST_VAL(FLAG_B_RST)) u_flag_b (
        .clk(clk), .rst(rst), .set_i(set_b),
        .clr_we_i(bus_we && sel == SEL_FLAG_B), .clr_data_i(bus_wdata),
        .flag_o(flag_b)
    );

    sticky_flags #(.W(8), .RST_VAL(8'h00)) u_flag_w (
        .clk(clk), .rst(rst), .set_i(set_w),
        .clr_we_i(bus_we && sel == SEL_WAKE_FLAG), .clr_data_i(bus_wdata),
        .flag_o(flag_w)
    );

    always_comb begin
        case (sel)
            SEL_SENSE:      bus_rdata = ctrl_q.sense;
            SEL_MASK_A:     bus_rdata = ctrl_q.mask_a;
            SEL_MASK_B:     bus_rdata = ctrl_q.mask_b;
            SEL_FLAG_A:     bus_rdata = flag_a;
            SEL_FLAG_B:     bus_rdata = flag_b;
            SEL_WAKE_FLAG:  bus_rdata = flag_w;
            SEL_WAKE_SENSE: bus_rdata = ctrl_q.wsense;
            default:        bus_rdata = '0;
        endcase
    end

    assign irq_o = (|(flag_a[N_IRQ-1:0] & ctrl_q.mask_a[N_IRQ-1:0]))
                 | (flag_b[0] & ctrl_q.mask_a[5])
                 | (flag_b[5] & ctrl_q.mask_a[6])
                 | (|(flag_w & ctrl_q.mask_b));

endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_rdata,
    input logic [7:0]  set_a,
    input logic [7:0]  set_b,
    input logic [7:0]  set_w,
    input logic [7:0]  flag_a,
    input logic [7:0]  flag_b,
    input logic [7:0]  flag_w,
    input logic        irq_o
);
    import edgeirq_pkg::*;

    // R1: first cycle out of reset shows the reset flag pattern
    a_r1_reset_flags: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flag_a == 8'h00 && flag_b == FLAG_B_RST && flag_w == 8'h00));

    // R2: reserved sense bits always read as ones
    a_r2_rsvd_ones: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SENSE) |-> (bus_rdata[7:5] == 3'b111));

    // R5: a flag only rises after a detector event
    a_r5_no_sw_set: assert property (@(posedge clk) disable iff (rst)
        ((flag_a & ~$past(flag_a) & ~$past(set_a)) == 8'h00) &&
        ((flag_b & ~$past(flag_b) & ~$past(set_b)) == 8'h00) &&
        ((flag_w & ~$past(flag_w) & ~$past(set_w)) == 8'h00));

    // R6: every detector event lands in its flag regardless of writes
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_a != 8'h00 || set_w != 8'h00) |=>
        (((flag_a & $past(set_a)) == $past(set_a)) && ((flag_w & $past(set_w)) == $past(set_w))));

    // R9: no flag set means no request
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (flag_a == 8'h00 && flag_b == 8'h00 && flag_w == 8'h00) |-> !irq_o);

endmodule

bind edge_irq_unit edge_irq_unit_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .set_a(set_a), .set_b(set_b), .set_w(set_w),
    .flag_a(flag_a), .flag_b(flag_b), .flag_w(flag_w), .irq_o(irq_o)
);

// File: tb/sim_edge_irq_unit.sv
`timescale 1ns/1ps
module sim_edge_irq_unit;
    import edgeirq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [4:0]  irq_pin = 5'h1F;
    logic        aux_trig = 1'b1;
    logic [7:0]  wake_pin = 8'hFF;
    logic        irq_o;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        is_irq;
        logic        irq;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    edge_irq_unit u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
        .aux_trig(aux_trig), .wake_pin(wake_pin), .irq_o(irq_o)
    );

    // Monitor: pops one expected item per cycle and compares after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (it.is_irq) begin
                    if (irq_o !== it.irq) begin
                        n_errors++;
                        $display("FAIL %s: irq_o actual=%0b expected=%0b", it.tag, irq_o, it.irq);
                    end
                end else if (bus_rdata !== it.data) begin
                    n_errors++;
                    $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.data);
                end
            end
        end
    end

    task automatic exp_rd(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{a, d, 1'b0, 1'b0, tag});
        wait (sb_q.size() == 0);
    endtask

    task automatic exp_irq(input logic v, input string tag);
        @(negedge clk);
        sb_q.push_back('{16'h0, 8'h0, 1'b1, v, tag});
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic direct(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R1 reset values
        exp_rd(A_SENSE,      8'hE0, "R1 sense");
        exp_rd(A_MASK_A,     8'h00, "R1 mask A");
        exp_rd(A_MASK_B,     8'h00, "R1 mask B");
        exp_rd(A_FLAG_A,     8'h00, "R1 flag A");
        exp_rd(A_FLAG_B,     8'h20, "R1 flag B");
        exp_rd(A_WAKE_FLAG,  8'h00, "R1 wake flags");
        exp_rd(A_WAKE_SENSE, 8'h00, "R1 wake sense");
        exp_irq(1'b0, "R1 irq");

        // R2 reserved sense bits
        wr(A_SENSE, 8'hFF);
        exp_rd(A_SENSE, 8'hFF, "R2 sense all ones");
        wr(A_SENSE, 8'h00);
        exp_rd(A_SENSE, 8'hE0, "R2 reserved stay one");

        // R10 unmapped address
        exp_rd(16'h1234, 8'h00, "R10 unmapped");

        // R3/R4 falling default on pin 0
        @(negedge clk); irq_pin[0] = 1'b0;
        settle();
        exp_rd(A_FLAG_A, 8'h01, "R3 falling pin0");

        // R3 rising on pin 1: fall ignored, rise counted
        wr(A_SENSE, 8'h02);
        exp_rd(A_SENSE, 8'hE2, "R2 sense low bits");
        @(negedge clk); irq_pin[1] = 1'b0;
        settle();
        exp_rd(A_FLAG_A, 8'h01, "R3 wrong direction ignored");
        @(negedge clk); irq_pin[1] = 1'b1;
        settle();
        exp_rd(A_FLAG_A, 8'h03, "R3 rising pin1");

        // R5 clear by zero, ones ignored
        wr(A_FLAG_A, 8'hFE);
        exp_rd(A_FLAG_A, 8'h02, "R5 clear bit0");
        wr(A_FLAG_A, 8'hFF);
        exp_rd(A_FLAG_A, 8'h02, "R5 ones have no effect");

        // R9 enable gating
        exp_irq(1'b0, "R9 masked");
        wr(A_MASK_A, 8'h02);
        exp_irq(1'b1, "R9 enabled flag");
        wr(A_FLAG_A, 8'h00);
        exp_rd(A_FLAG_A, 8'h00, "R5 clear all");
        exp_irq(1'b0, "R9 cleared");

        // R7 sense change with steady pin
        wr(A_SENSE, 8'h06);
        settle();
        exp_rd(A_FLAG_A, 8'h00, "R7 select rising on high pin");
        @(negedge clk); irq_pin[2] = 1'b0;
        settle();
        wr(A_SENSE, 8'h02);
        settle();
        exp_rd(A_FLAG_A, 8'h00, "R7 select falling on low pin");

        // R8 aux trigger follows sense bit 4
        wr(A_SENSE, 8'h12);
        @(negedge clk); aux_trig = 1'b0; irq_pin[4] = 1'b0;
        settle();
        exp_rd(A_FLAG_B, 8'h20, "R8 aux falling ignored");
        @(negedge clk); aux_trig = 1'b1; irq_pin[4] = 1'b1;
        settle();
        exp_rd(A_FLAG_B, 8'h21, "R8 aux rising");
        exp_rd(A_FLAG_A, 8'h10, "R8 pin4 rising");
        wr(A_MASK_A, 8'h20);
        exp_irq(1'b1, "R9 aux enable");
        wr(A_FLAG_B, 8'hFE);
        exp_rd(A_FLAG_B, 8'h20, "R5 clear aux flag");
        exp_irq(1'b0, "R9 aux cleared");
        wr(A_MASK_A, 8'h40);
        exp_irq(1'b1, "R9 reset flag enable");
        wr(A_FLAG_B, 8'hDF);
        exp_rd(A_FLAG_B, 8'h00, "R5 clear reset flag");
        wr(A_MASK_A, 8'h00);

        // R3 wakeup polarity
        @(negedge clk); wake_pin[3] = 1'b0;
        settle();
        exp_rd(A_WAKE_FLAG, 8'h08, "R3 wake falling");
        wr(A_MASK_B, 8'h08);
        exp_irq(1'b1, "R9 wake enable");
        wr(A_WAKE_SENSE, 8'h01);
        exp_rd(A_WAKE_SENSE, 8'h01, "R10 wake sense");
        @(negedge clk); wake_pin[0] = 1'b0;
        settle();
        exp_rd(A_WAKE_FLAG, 8'h08, "R3 wake wrong direction");
        @(negedge clk); wake_pin[0] = 1'b1;
        settle();
        exp_rd(A_WAKE_FLAG, 8'h09, "R3 wake rising");

        // R4 exact latency on wake pin 5
        wait (sb_q.size() == 0);
        @(negedge clk); wake_pin[5] = 1'b0; bus_addr = A_WAKE_FLAG;
        @(posedge clk); #1;
        direct(bus_rdata[5] == 1'b0, "R4 edge+1", bus_rdata, 8'h09);
        @(posedge clk); #1;
        direct(bus_rdata[5] == 1'b0, "R4 edge+2", bus_rdata, 8'h09);
        @(posedge clk); #1;
        direct(bus_rdata == 8'h29, "R4 edge+3", bus_rdata, 8'h29);
        settle();
        @(negedge clk); wake_pin[5] = 1'b1;
        settle();
        exp_rd(A_WAKE_FLAG, 8'h29, "R4 flag sticky");

        // R6 set wins over same-cycle clear on pin 0 (falling sense)
        wr(A_FLAG_A, 8'h00);
        @(negedge clk); irq_pin[0] = 1'b1;
        settle();
        exp_rd(A_FLAG_A, 8'h00, "R6 precondition");
        @(negedge clk); irq_pin[0] = 1'b0;
        @(negedge clk);
        wr(A_FLAG_A, 8'h00);
        exp_rd(A_FLAG_A, 8'h01, "R6 set wins");

        settle();
        finish_run();
    end

endmodule